// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block derives slower clocks from one input clock. A ratio may be a whole number or a whole number plus one half, so a 250 MHz input can yield 100 MHz (ratio 2.5) as well as 125 MHz (ratio 2). Each channel holds a ratio code equal to twice its divisor. The code counts half periods of the input clock, and the channel steps through it on both edges of the input clock.

Two channels share one 32-bit configuration word, which is loaded through a single-cycle write strobe. The system channel takes a 6-bit selector that an internal lookup turns into a code. The lookup is sparse and not monotonic. The auxiliary channel takes its code straight from an 8-bit field. A selector or code that has no meaning parks that channel's output low and raises its own invalid flag. A new ratio is adopted only at the channel's next rising output edge, so a change in the middle of a period never shortens a pulse.

Top module: `hdiv_sysclk`

## Requirements
- R1: While `rst` is high, both outputs go low and both invalid flags go low within one input period. After reset the configuration word holds selector 0 and auxiliary code 4.
- R2: The system selector sits in word bits 31:26. Selector values 0 to 6 give code value+4. Selector 7 gives 14 and selector 8 gives 12. From selector 7 upward, take k = selector-5. The code is then 8 + 8*floor(k/4) plus an offset picked by k mod 4: 0, 2, 6 or 4. The top selector, 34, gives 66.
- R3: For a valid code C, the output period is C half periods of the input clock. The output is high for ceil(C/2) half periods and low for floor(C/2).
- R4: The auxiliary code is word bits 7:0. Any code from 2 to 255 follows the rule of R3.
- R5: A system selector from 35 to 63 holds `sys_clk_o` low and sets `sys_bad_o`.
- R6: An auxiliary code of 0 or 1 holds `aux_clk_o` low and sets `aux_bad_o`.
- R7: A ratio change takes effect at the next rising edge of the output. Every high and low pulse around the change has the width of either the old ratio or the new ratio.
- R8: Once a valid value replaces an invalid one, the flag clears and the output resumes with a rising edge.
- R9: Word bits 25:8 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: selector 31:26, auxiliary code 7:0 |
| sys_clk_o | output | 1 | Divided system-channel clock |
| aux_clk_o | output | 1 | Divided auxiliary-channel clock |
| sys_bad_o | output | 1 | System selector is out of range |
| aux_bad_o | output | 1 | Auxiliary code is below 2 |

## Verification
The hardest case to reach is a ratio write that lands in the middle of an output period, and above all one that lands while an odd code has put the period boundary on a falling input edge. In that case the switch point falls half a cycle away from a rising input edge. The stimulus runs an odd code (2.5) and writes a much longer ratio (7.0), and later writes the short ratio back. Each write is issued while a pulse monitor is already timing every high and low pulse. Invalid values are driven the same way, in the middle of a period, so that parking the output and later restarting it both happen at a phase the write did not choose.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  localparam int SEL_W    = 6;
  localparam int CODE_W   = 8;
  localparam int SEL_LAST = 34;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              bad;
  } hdiv_ratio_t;

  // Selector to "twice the divisor" code, computed from its group structure.
  function automatic logic [CODE_W-1:0] sel_to_code(input logic [SEL_W-1:0] sel);
    logic [CODE_W-1:0] k;
    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] offs;
    if (sel < SEL_W'(7)) begin
      sel_to_code = CODE_W'(sel) + CODE_W'(4);
    end else begin
      k    = CODE_W'(sel) - CODE_W'(5);
      base = CODE_W'(8) + ((k >> 2) << 3);
      offs = CODE_W'({k[1], k[1] ^ k[0], 1'b0});
      sel_to_code = base + offs;
    end
  endfunction

endpackage

// File: rtl/hdiv_cfg_reg.sv
module hdiv_cfg_reg #(
  parameter int          W       = 14,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end

endmodule

// File: rtl/hdiv_decode.sv
module hdiv_decode
  import hdiv_pkg::*;
#(
  parameter int AUX_W = CODE_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [AUX_W-1:0] aux,
  output hdiv_ratio_t      ratio [2]
);

  // Channel 0: selector through the lookup; channel 1: code taken directly.
  always_comb begin
    ratio[0].code = sel_to_code(sel);
    ratio[0].bad  = (sel > SEL_W'(SEL_LAST));
    ratio[1].code = CODE_W'(aux);
    ratio[1].bad  = (aux < AUX_W'(2));
  end

endmodule

// File: rtl/hdiv_core.sv
module hdiv_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_i,
  input  logic         bad_i,
  output logic         clk_o,
  output logic         bad_o
);

  localparam int RW = W + 1;

  // hp_q: half-period index at the last rising input edge (0..act_q-1)
  logic [W-1:0]  act_q, hp_q;
  logic          run_q, bad_q, tp_q, tn_q;
  logic [RW-1:0] r_w, act_w, h_w;
  logic          at_rise, pre_rise, wrap_one, two_slip;
  logic [W-1:0]  idx_p, idx_n;
  logic          lvl_p, lvl_n;

  always_comb begin
    r_w      = {1'b0, hp_q} + RW'(2);
    act_w    = {1'b0, act_q};
    h_w      = (act_w + RW'(1)) >> 1;
    at_rise  = (r_w == act_w);
    pre_rise = ((r_w + RW'(1)) == act_w);
    wrap_one = (r_w == (act_w + RW'(1)));
    two_slip = wrap_one && (act_q == W'(2));
    idx_p    = wrap_one ? W'(1) : r_w[W-1:0];
    lvl_p    = ({1'b0, idx_p} < h_w);
    idx_n    = (({1'b0, hp_q} + RW'(1)) == act_w) ? '0 : hp_q + W'(1);
    lvl_n    = ({1'b0, idx_n} < h_w);
  end

  // Rising-edge half: owns the index and the switch points.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      hp_q  <= '0;
      run_q <= 1'b0;
      bad_q <= 1'b0;
      tp_q  <= 1'b0;
    end else if (!run_q || at_rise) begin
      act_q <= code_i;
      hp_q  <= '0;
      run_q <= !bad_i;
      bad_q <= bad_i;
      tp_q  <= tn_q ^ !bad_i;
    end else if (pre_rise) begin
      act_q <= code_i;
      hp_q  <= code_i - W'(1);
      run_q <= !bad_i;
      bad_q <= bad_i;
      tp_q  <= tn_q;
    end else if (two_slip) begin
      act_q <= code_i;
      hp_q  <= W'(1);
      run_q <= !bad_i;
      bad_q <= bad_i;
      tp_q  <= tn_q ^ (!bad_i && (code_i > W'(2)));
    end else begin
      hp_q  <= idx_p;
      tp_q  <= tn_q ^ lvl_p;
    end
  end

  // Falling-edge half: sets the level for the odd half periods.
  always_ff @(negedge clk) begin
    if (rst)         tn_q <= 1'b0;
    else if (!run_q) tn_q <= tp_q;
    else             tn_q <= tp_q ^ lvl_n;
  end

  assign clk_o = tp_q ^ tn_q;
  assign bad_o = bad_q;

endmodule

// File: rtl/hdiv_sysclk.sv
module hdiv_sysclk
  import hdiv_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int SEL_LSB = 26,
  parameter int AUX_LSB = 0,
  parameter int AUX_W   = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sys_clk_o,
  output logic             aux_clk_o,
  output logic             sys_bad_o,
  output logic             aux_bad_o
);

  localparam int FLD_W = SEL_W + AUX_W;
  localparam int NCH   = 2;
  localparam logic [FLD_W-1:0] FLD_RST = {SEL_W'(0), AUX_W'(4)};

  logic [FLD_W-1:0] fld_d, fld_q;
  logic             unused_bits;
  hdiv_ratio_t      ratio [NCH];
  logic [NCH-1:0]   ch_clk, ch_bad;

  assign fld_d       = {cfg_wdata[SEL_LSB +: SEL_W], cfg_wdata[AUX_LSB +: AUX_W]};
  assign unused_bits = ^cfg_wdata[SEL_LSB-1:AUX_LSB+AUX_W];

  hdiv_cfg_reg #(.W(FLD_W), .RST_VAL(FLD_RST)) u_cfg (
    .clk (clk),
    .rst (rst),
    .we  (cfg_we),
    .d   (fld_d),
    .q   (fld_q)
  );

  hdiv_decode #(.AUX_W(AUX_W)) u_dec (
    .sel   (fld_q[FLD_W-1 -: SEL_W]),
    .aux   (fld_q[AUX_W-1:0]),
    .ratio (ratio)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hdiv_core #(.W(CODE_W)) u_core (
      .clk    (clk),
      .rst    (rst),
      .code_i (ratio[g].code),
      .bad_i  (ratio[g].bad),
      .clk_o  (ch_clk[g]),
      .bad_o  (ch_bad[g])
    );
  end

  assign sys_clk_o = ch_clk[0];
  assign aux_clk_o = ch_clk[1];
  assign sys_bad_o = ch_bad[0];
  assign aux_bad_o = ch_bad[1];

endmodule

// File: rtl/hdiv_sysclk_chk.sv
module hdiv_sysclk_chk #(
  parameter int MAX_HI = 17
) (
  input logic clk,
  input logic rst,
  input logic sys_clk_o,
  input logic aux_clk_o,
  input logic sys_bad_o,
  input logic aux_bad_o
);

  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                      hi_run <= '0;
    else if (!sys_clk_o)          hi_run <= '0;
    else if (hi_run != 8'hFF)     hi_run <= hi_run + 8'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (!sys_clk_o && !aux_clk_o && !sys_bad_o && !aux_bad_o));

  p_high_bound_r3: assert property (@(posedge clk) disable iff (rst)
    hi_run <= 8'(MAX_HI));

  p_sys_park_r5: assert property (@(posedge clk) disable iff (rst)
    sys_bad_o |-> !sys_clk_o);

  p_aux_park_r6: assert property (@(posedge clk) disable iff (rst)
    aux_bad_o |-> !aux_clk_o);

  p_restart_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_bad_o) |-> sys_clk_o);

endmodule

bind hdiv_sysclk hdiv_sysclk_chk #(.MAX_HI(17)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_clk_o (sys_clk_o),
  .aux_clk_o (aux_clk_o),
  .sys_bad_o (sys_bad_o),
  .aux_bad_o (aux_bad_o)
);

// File: tb/hdiv_sysclk_tb.sv
`timescale 1ns/1ps
module hdiv_sysclk_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sys_clk_o, aux_clk_o, sys_bad_o, aux_bad_o;

  always #2 clk = ~clk;   // 250 MHz

  hdiv_sysclk u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sys_clk_o (sys_clk_o),
    .aux_clk_o (aux_clk_o),
    .sys_bad_o (sys_bad_o),
    .aux_bad_o (aux_bad_o)
  );

  typedef struct {
    int    per;
    int    hi;
    string req;
  } exp_t;

  exp_t q_sys[$];
  exp_t q_aux[$];
  int   n_tests = 0;
  int   n_fail  = 0;

  // Codes from R2, written out independently.
  int tbl [35] = '{4, 5, 6, 7, 8, 9, 10, 14, 12, 16, 18, 22, 20, 24, 26, 30, 28, 32,
                   34, 38, 36, 40, 42, 46, 44, 48, 50, 54, 52, 56, 58, 62, 60, 64, 66};

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] word(input int sel, input int aux, input logic [17:0] mid);
    return {sel[5:0], mid, aux[7:0]};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(posedge clk);
  endtask

  // Driver: queue expected periods for a channel and wait for the monitor.
  task automatic expect_run(input bit ch, input int code, input int reps, input string req);
    exp_t e;
    e.per = code * 2;
    e.hi  = ((code + 1) / 2) * 2;
    e.req = req;
    for (int i = 0; i < reps; i++) begin
      if (ch) q_aux.push_back(e);
      else    q_sys.push_back(e);
    end
    while ((ch ? q_aux.size() : q_sys.size()) != 0) @(posedge clk);
  endtask

  // Monitors: time one full period from a rising edge and compare.
  initial begin : mon_sys
    int t0, t1, t2;
    exp_t e;
    forever begin
      while (q_sys.size() == 0) @(posedge clk);
      @(posedge sys_clk_o); t0 = int'($time);
      @(negedge sys_clk_o); t1 = int'($time);
      @(posedge sys_clk_o); t2 = int'($time);
      e = q_sys.pop_front();
      check((t2 - t0) == e.per, {e.req, " sys period"}, t2 - t0, e.per);
      check((t1 - t0) == e.hi,  {e.req, " sys high"},   t1 - t0, e.hi);
    end
  end

  initial begin : mon_aux
    int t0, t1, t2;
    exp_t e;
    forever begin
      while (q_aux.size() == 0) @(posedge clk);
      @(posedge aux_clk_o); t0 = int'($time);
      @(negedge aux_clk_o); t1 = int'($time);
      @(posedge aux_clk_o); t2 = int'($time);
      e = q_aux.pop_front();
      check((t2 - t0) == e.per, {e.req, " aux period"}, t2 - t0, e.per);
      check((t1 - t0) == e.hi,  {e.req, " aux high"},   t1 - t0, e.hi);
    end
  end

  // Output parked low with flag high, sampled away from both edges.
  task automatic hold_check(input bit ch, input string req);
    int bad_lvl = 0;
    int bad_flg = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if ((ch ? aux_clk_o : sys_clk_o) !== 1'b0) bad_lvl++;
      if ((ch ? aux_bad_o : sys_bad_o) !== 1'b1) bad_flg++;
      @(negedge clk); #1;
      if ((ch ? aux_clk_o : sys_clk_o) !== 1'b0) bad_lvl++;
    end
    check(bad_lvl == 0, {req, " output parked low"}, bad_lvl, 0);
    check(bad_flg == 0, {req, " flag held"}, bad_flg, 0);
  endtask

  // R7: every pulse around a switch has the old or the new width.
  task automatic watch_pulses(input int ha, input int hb, input int la, input int lb);
    int t, w, odd;
    odd = 0;
    @(posedge sys_clk_o); t = int'($time);
    for (int i = 0; i < 10; i++) begin
      @(negedge sys_clk_o); w = int'($time) - t; t = int'($time);
      if (w != ha && w != hb) odd++;
      @(posedge sys_clk_o); w = int'($time) - t; t = int'($time);
      if (w != la && w != lb) odd++;
    end
    check(odd == 0, "R7 pulse widths across switch", odd, 0);
  endtask

  initial begin : watchdog
    #700000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1;
    check(sys_clk_o == 1'b0, "R1 sys low in reset", sys_clk_o, 0);
    check(aux_clk_o == 1'b0, "R1 aux low in reset", aux_clk_o, 0);
    check(sys_bad_o == 1'b0, "R1 sys flag low in reset", sys_bad_o, 0);
    check(aux_bad_o == 1'b0, "R1 aux flag low in reset", aux_bad_o, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset configuration is selector 0 (code 4) and aux code 4
    expect_run(1'b0, 4, 3, "R1");
    expect_run(1'b1, 4, 3, "R1");

    // R2 / R3: selector sweep over the lookup, odd and even codes
    foreach (tbl[s]) begin
      if (s == 1 || s == 2 || s == 7 || s == 8 || s == 11 || s == 20 || s == 34) begin
        wr(word(s, 4, '0));
        settle();
        expect_run(1'b0, tbl[s], 2, (s == 1) ? "R3" : "R2");
      end
    end

    // R4: auxiliary codes straight from the field
    wr(word(0, 2, '0));   settle(); expect_run(1'b1, 2, 3, "R4");
    wr(word(0, 3, '0));   settle(); expect_run(1'b1, 3, 3, "R4");
    wr(word(0, 9, '0));   settle(); expect_run(1'b1, 9, 2, "R4");
    wr(word(0, 255, '0)); repeat (600) @(posedge clk); expect_run(1'b1, 255, 2, "R4");

    // R9: middle bits set, ratios unchanged
    wr(word(2, 6, 18'h3FFFF));
    settle();
    expect_run(1'b0, 6, 2, "R9");
    expect_run(1'b1, 6, 2, "R9");

    // R5: selectors beyond the table
    wr(word(35, 6, '0)); settle(); hold_check(1'b0, "R5 sel35");
    wr(word(63, 6, '0)); settle(); hold_check(1'b0, "R5 sel63");

    // R8: recovery from the invalid selector
    wr(word(1, 6, '0));
    repeat (4) @(posedge clk); #1;
    check(sys_bad_o == 1'b0, "R8 sys flag clears", sys_bad_o, 0);
    expect_run(1'b0, 5, 2, "R8");

    // R6: auxiliary codes below two
    wr(word(1, 0, '0)); settle(); hold_check(1'b1, "R6 aux0");
    wr(word(1, 1, '0)); settle(); hold_check(1'b1, "R6 aux1");
    wr(word(1, 3, '0));
    repeat (4) @(posedge clk); #1;
    check(aux_bad_o == 1'b0, "R8 aux flag clears", aux_bad_o, 0);
    expect_run(1'b1, 3, 2, "R8");

    // R7: switch 2.5 -> 7.0 and back, written in the middle of a period
    fork
      watch_pulses(6, 14, 4, 14);
      begin repeat (11) @(posedge clk); wr(word(7, 3, '0)); end
    join
    expect_run(1'b0, 14, 2, "R7");
    fork
      watch_pulses(6, 14, 4, 14);
      begin repeat (9) @(posedge clk); wr(word(1, 3, '0)); end
    join
    expect_run(1'b0, 5, 2, "R7");

    // R1: reset while running
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk); #1;
    check(sys_clk_o == 1'b0, "R1 sys low after mid-run reset", sys_clk_o, 0);
    check(aux_clk_o == 1'b0, "R1 aux low after mid-run reset", aux_clk_o, 0);
    @(negedge clk); rst = 1'b0;
    expect_run(1'b0, 4, 2, "R1");
    expect_run(1'b1, 4, 2, "R1");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule